// File: doc/BRIEF.md
# Transmit Buffer Command Parser and Packet Checker

This block reads a host-filled stream of 32-bit words and turns it into a byte stream for a MAC transmitter. The words form buffers. Each buffer opens with two command words and then carries payload words. The first command word sets the size of the buffer, the byte at which its payload starts, and whether the buffer opens or closes a packet. The second command word holds a 16-bit tag and the declared length of the packet. A packet may be spread over several buffers, and each buffer can start its payload on any byte.

The block drops the bytes in front of the start offset and the padding after the last payload byte. It sends the payload bytes one at a time through a valid/ready port that marks the first and last byte of each packet. It checks that every buffer of a packet repeats the tag and length of the opening buffer, and it counts the bytes it actually sends. When a packet closes, it writes one status word that holds the tag, an error flag and the byte count. An errored packet is still read through to its closing buffer, so the word stream stays aligned.

Top module: `txbuf_framer`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` and `sts_write` are low and `fifo_ready` is high, waiting for a command word.
- R2: Each buffer takes exactly two words before its payload. In the first word, [10:0] is the payload size in bytes, bit 12 marks the closing buffer, bit 13 marks the opening buffer, and [20:16] is the start offset in bytes. In the second word, [31:16] is the tag and [10:0] is the declared packet length.
- R3: Payload bytes leave each word in little-endian order: [7:0] first and [31:24] last.
- R4: The bytes in front of the start offset are dropped. The offset can be anywhere from 0 to 31, so it can reach into the eighth word of the buffer.
- R5: After the size bytes of a buffer have been sent, the rest of the current word is dropped, and the next word read is the first command word of the next buffer. A buffer of size zero sends nothing.
- R6: `out_first` is high on the first byte sent for a packet. `out_last` is high on the final byte of a closing buffer whose size is not zero.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_first` and `out_last` hold their values.
- R8: After each closing buffer, the block writes exactly one status word. The tag of the opening buffer is in [31:16], the error flag in bit 15, zeros in [14:12], and the number of bytes sent in [11:0].
- R9: The error flag is set when the tag of any later buffer differs from the tag of the opening buffer.
- R10: The error flag is set when the declared length of any later buffer differs from the length of the opening buffer.
- R11: The error flag is set when the number of bytes sent differs from the declared length of the opening buffer.
- R12: A packet with an error is still read and sent up to its closing buffer. The packet after it starts clean.
- R13: `sts_write` is never high while `sts_full` is high. A pending status waits until the status FIFO has space and is then written unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_data | input | 32 | Head word of the transmit data FIFO |
| fifo_valid | input | 1 | FIFO head word is present |
| fifo_ready | output | 1 | Pops the head word on this edge when `fifo_valid` is high |
| out_data | output | 8 | Payload byte to the MAC |
| out_valid | output | 1 | `out_data` is valid |
| out_first | output | 1 | First byte of a packet |
| out_last | output | 1 | Last byte of a packet |
| out_ready | input | 1 | MAC accepts the byte |
| sts_data | output | 32 | Packet status word |
| sts_write | output | 1 | Writes `sts_data` into the status FIFO |
| sts_full | input | 1 | Status FIFO cannot take a word |

## Verification
The assertions assume that the word stream is well formed. Every packet opens with a buffer that has the opening flag set and closes with one that has the closing flag set. The host keeps `out_ready` and `sts_full` steady between clock edges. One assertion expects the byte after a closing byte to open a new packet, and that holds only under this framing. The stimulus table always starts a packet with an opening buffer and ends it with a closing one, including the zero-size middle buffer. It drives the two back-pressure inputs only just after a rising edge. Errors are introduced only through tag, length and size values, never through broken framing.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int TAG_W          = 16;
  localparam int CMDA_LAST_BIT  = 12;
  localparam int CMDA_FIRST_BIT = 13;
  localparam int CMDA_OFF_LSB   = 16;
  localparam int CMDB_TAG_LSB   = 16;
  localparam int STS_ERR_BIT    = 15;

  typedef enum logic [1:0] {
    ST_CMDA = 2'd0,
    ST_CMDB = 2'd1,
    ST_DATA = 2'd2,
    ST_STAT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/txbuf_out_reg.sv
module txbuf_out_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       load_first,
  input  logic       load_last,
  output logic       slot_free,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_first,
  output logic       out_last,
  input  logic       out_ready
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_first <= load_first;
      out_last  <= load_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                 && $stable(out_first) && $stable(out_last));
endmodule

// File: rtl/txbuf_seq.sv
module txbuf_seq
  import txbuf_pkg::*;
#(
  parameter int SIZE_W = 11,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       fifo_data,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  input  logic              slot_free,
  input  logic              pkt_empty,
  output logic              emit,
  output logic [7:0]        emit_byte,
  output logic              emit_first,
  output logic              emit_last,
  output logic              cmdb_fire,
  output logic              cmdb_first,
  output logic [TAG_W-1:0]  cmdb_tag,
  output logic [SIZE_W-1:0] cmdb_len,
  output logic              close,
  output logic              in_stat,
  input  logic              stat_done
);
  localparam int POS_W = ((SIZE_W > OFF_W) ? SIZE_W : OFF_W) + 2;

  seq_state_e         state_q;
  logic [SIZE_W-1:0]  size_q;
  logic [OFF_W-1:0]   off_q;
  logic               last_q;
  logic               first_q;
  logic [POS_W-1:0]   pos_q;
  logic [POS_W-1:0]   end_q;
  logic [POS_W-1:0]   lim;
  logic               have_word;
  logic [31:0]        word_q;
  logic               at_end;
  logic               in_pay;
  logic               byte_go;

  always_comb begin
    lim        = (end_q + POS_W'(3)) & ~POS_W'(3);
    at_end     = (state_q == ST_DATA) && (pos_q == lim);
    in_pay     = (pos_q >= POS_W'(off_q)) && (pos_q < end_q);
    byte_go    = (state_q == ST_DATA) && !at_end && have_word
                 && (!in_pay || slot_free);
    emit       = byte_go && in_pay;
    emit_byte  = word_q[8*pos_q[1:0] +: 8];
    emit_first = pkt_empty;
    emit_last  = last_q && (pos_q == end_q - POS_W'(1));
    fifo_ready = (state_q == ST_CMDA) || (state_q == ST_CMDB)
                 || ((state_q == ST_DATA) && !at_end && !have_word);
    cmdb_fire  = (state_q == ST_CMDB) && fifo_valid;
    cmdb_first = first_q;
    cmdb_tag   = fifo_data[CMDB_TAG_LSB +: TAG_W];
    cmdb_len   = fifo_data[SIZE_W-1:0];
    close      = at_end && last_q;
    in_stat    = (state_q == ST_STAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_CMDA;
      size_q    <= '0;
      off_q     <= '0;
      last_q    <= 1'b0;
      first_q   <= 1'b0;
      pos_q     <= '0;
      end_q     <= '0;
      have_word <= 1'b0;
      word_q    <= '0;
    end else begin
      case (state_q)
        ST_CMDA: if (fifo_valid) begin
          size_q  <= fifo_data[SIZE_W-1:0];
          last_q  <= fifo_data[CMDA_LAST_BIT];
          first_q <= fifo_data[CMDA_FIRST_BIT];
          off_q   <= fifo_data[CMDA_OFF_LSB +: OFF_W];
          state_q <= ST_CMDB;
        end
        ST_CMDB: if (fifo_valid) begin
          pos_q     <= '0;
          end_q     <= POS_W'(off_q) + POS_W'(size_q);
          have_word <= 1'b0;
          state_q   <= ST_DATA;
        end
        ST_DATA: begin
          if (at_end) begin
            state_q <= last_q ? ST_STAT : ST_CMDA;
          end else if (!have_word) begin
            if (fifo_valid) begin
              word_q    <= fifo_data;
              have_word <= 1'b1;
            end
          end else if (byte_go) begin
            pos_q <= pos_q + POS_W'(1);
            if (pos_q[1:0] == 2'd3) have_word <= 1'b0;
          end
        end
        ST_STAT: if (stat_done) state_q <= ST_CMDA;
        default: state_q <= ST_CMDA;
      endcase
    end
  end

  // R2
  payload_starts_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA) && ($past(state_q) == ST_CMDB) |-> (pos_q == '0) && !have_word);

  // R5
  pos_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA) |-> (pos_q <= lim));
endmodule

// File: rtl/txbuf_pkt_check.sv
module txbuf_pkt_check
  import txbuf_pkg::*;
#(
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdb_fire,
  input  logic              cmdb_first,
  input  logic [TAG_W-1:0]  cmdb_tag,
  input  logic [SIZE_W-1:0] cmdb_len,
  input  logic              byte_fire,
  input  logic              close,
  input  logic              in_stat,
  input  logic              stat_done,
  output logic              pkt_empty,
  output logic [31:0]       sts_data
);
  localparam int CNT_W = SIZE_W + 1;

  logic [TAG_W-1:0]  tag_q;
  logic [SIZE_W-1:0] len_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;

  assign pkt_empty = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q    <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
      sts_data <= '0;
    end else begin
      if (cmdb_fire) begin
        if (cmdb_first) begin
          tag_q <= cmdb_tag;
          len_q <= cmdb_len;
          cnt_q <= '0;
          err_q <= 1'b0;
        end else begin
          err_q <= err_q || (cmdb_tag != tag_q) || (cmdb_len != len_q);
        end
      end else if (byte_fire) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (close) begin
        sts_data                     <= '0;
        sts_data[31:CMDB_TAG_LSB]    <= tag_q;
        sts_data[STS_ERR_BIT]        <= err_q || (cnt_q != CNT_W'(len_q));
        sts_data[CNT_W-1:0]          <= cnt_q;
      end
    end
  end

  // R8
  count_settled_chk: assert property (@(posedge clk) disable iff (rst)
    close |-> !byte_fire && !cmdb_fire);

  // R13
  status_held_chk: assert property (@(posedge clk) disable iff (rst)
    in_stat && !stat_done |=> $stable(sts_data));
endmodule

// File: rtl/txbuf_framer.sv
module txbuf_framer
  import txbuf_pkg::*;
#(
  parameter int SIZE_W = 11,
  parameter int OFF_W  = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] fifo_data,
  input  logic        fifo_valid,
  output logic        fifo_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_first,
  output logic        out_last,
  input  logic        out_ready,
  output logic [31:0] sts_data,
  output logic        sts_write,
  input  logic        sts_full
);
  logic              slot_free;
  logic              pkt_empty;
  logic              emit;
  logic [7:0]        emit_byte;
  logic              emit_first;
  logic              emit_last;
  logic              cmdb_fire;
  logic              cmdb_first;
  logic [TAG_W-1:0]  cmdb_tag;
  logic [SIZE_W-1:0] cmdb_len;
  logic              close;
  logic              in_stat;

  assign sts_write = in_stat && !sts_full;

  txbuf_seq #(.SIZE_W(SIZE_W), .OFF_W(OFF_W)) u_seq (
    .clk(clk), .rst(rst),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .slot_free(slot_free), .pkt_empty(pkt_empty),
    .emit(emit), .emit_byte(emit_byte), .emit_first(emit_first), .emit_last(emit_last),
    .cmdb_fire(cmdb_fire), .cmdb_first(cmdb_first), .cmdb_tag(cmdb_tag), .cmdb_len(cmdb_len),
    .close(close), .in_stat(in_stat), .stat_done(sts_write)
  );

  txbuf_pkt_check #(.SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst(rst),
    .cmdb_fire(cmdb_fire), .cmdb_first(cmdb_first), .cmdb_tag(cmdb_tag), .cmdb_len(cmdb_len),
    .byte_fire(emit), .close(close), .in_stat(in_stat), .stat_done(sts_write),
    .pkt_empty(pkt_empty), .sts_data(sts_data)
  );

  txbuf_out_reg u_out (
    .clk(clk), .rst(rst),
    .load(emit), .load_data(emit_byte), .load_first(emit_first), .load_last(emit_last),
    .slot_free(slot_free),
    .out_data(out_data), .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_ready(out_ready)
  );

  // R6
  last_then_first_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid || out_first);
endmodule

// File: tb/txbuf_framer_bench.sv
`timescale 1ns/1ps
module txbuf_framer_bench;
  localparam int NV = 15;
  // {open, close, offset[4:0], size[10:0], tag[15:0], length[10:0]}
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 1'b1, 5'd0,  11'd8,  16'h1111, 11'd8},
    {1'b1, 1'b0, 5'd3,  11'd5,  16'h2222, 11'd12},
    {1'b0, 1'b1, 5'd6,  11'd7,  16'h2222, 11'd12},
    {1'b1, 1'b1, 5'd31, 11'd1,  16'h3333, 11'd1},
    {1'b1, 1'b0, 5'd1,  11'd4,  16'h4444, 11'd9},
    {1'b0, 1'b1, 5'd2,  11'd5,  16'h4445, 11'd9},
    {1'b1, 1'b0, 5'd0,  11'd3,  16'h5555, 11'd6},
    {1'b0, 1'b1, 5'd0,  11'd3,  16'h5555, 11'd7},
    {1'b1, 1'b1, 5'd2,  11'd10, 16'h6666, 11'd9},
    {1'b1, 1'b1, 5'd0,  11'd1,  16'h7777, 11'd1},
    {1'b1, 1'b0, 5'd0,  11'd4,  16'h8888, 11'd6},
    {1'b0, 1'b0, 5'd1,  11'd0,  16'h8888, 11'd6},
    {1'b0, 1'b1, 5'd3,  11'd2,  16'h8888, 11'd6},
    {1'b1, 1'b1, 5'd5,  11'd13, 16'h9999, 11'd13},
    {1'b1, 1'b1, 5'd2,  11'd3,  16'hABCD, 11'd3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fifo_data;
  logic        fifo_valid;
  logic        fifo_ready;
  logic [7:0]  out_data;
  logic        out_valid, out_first, out_last;
  logic        out_ready = 1'b0;
  logic [31:0] sts_data;
  logic        sts_write;
  logic        sts_full = 1'b0;

  logic [31:0] mem [256];
  logic [8:0]  rd = '0;
  int          limit = 0;
  int          wend [NV];
  logic [7:0]  exp_b [128];
  logic        exp_f [128], exp_l [128];
  logic [31:0] exp_s [32];
  int          ne = 0, ns = 0, ne1 = 0, ns1 = 0;
  logic [7:0]  cap_b [128];
  logic        cap_f [128], cap_l [128];
  logic [31:0] cap_s [32];
  int          nc = 0, nsg = 0;
  int          vec_n = 0, miss_n = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        hold_full = 1'b0, ready_all = 1'b0;
  logic        prev_stall = 1'b0;
  logic [9:0]  prev_out;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  assign fifo_valid = (int'(rd) < limit);
  assign fifo_data  = mem[rd[7:0]];

  txbuf_framer u_txbuf_framer (
    .clk(clk), .rst(rst),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .out_data(out_data), .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_ready(out_ready),
    .sts_data(sts_data), .sts_write(sts_write), .sts_full(sts_full)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    vec_n++;
    if (!ok) begin
      miss_n++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(int v, int p);
    return 8'(v * 29 + p * 7 + 1);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_valid && fifo_ready) rd <= rd + 9'd1;
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= ready_all ? 1'b1 : (lfsr[0] | lfsr[3]);
    sts_full  <= hold_full ? 1'b1 : (lfsr[5] & lfsr[2]);
  end

  always @(negedge clk) begin
    if (!rst) begin
      // R7: held byte while stalled
      if (prev_stall)
        chk(out_valid && ({out_data, out_first, out_last} == prev_out),
            "R7 stall hold", {22'd0, out_data, out_first, out_last}, {22'd0, prev_out});
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_data, out_first, out_last};
      if (out_valid && out_ready && nc < 128) begin
        cap_b[nc] = out_data; cap_f[nc] = out_first; cap_l[nc] = out_last; nc++;
      end
      if (sts_write && nsg < 32) begin
        cap_s[nsg] = sts_data; nsg++;
      end
      // R13: never write into a full status FIFO
      if (sts_write && sts_full) chk(1'b0, "R13 write while full", 32'd1, 32'd0);
    end
  end

  task automatic wait_for(input int bytes, input int stats);
    int t = 0;
    while ((nc < bytes || nsg < stats) && t < 20000) begin
      @(negedge clk); t++;
    end
    if (t >= 20000) chk(1'b0, "watchdog expired", 32'(nc), 32'(bytes));
  endtask

  initial begin
    int w = 0;
    int cnt = 0;
    logic [15:0] ptag = '0;
    logic [10:0] plen = '0;
    logic perr = 1'b0;
    for (int v = 0; v < NV; v++) begin
      logic op, cl;
      int off, sz, nb;
      logic [15:0] tg;
      logic [10:0] ln;
      logic [31:0] a;
      op = VEC[v][44]; cl = VEC[v][43]; off = int'(VEC[v][42:38]); sz = int'(VEC[v][37:27]);
      tg = VEC[v][26:11]; ln = VEC[v][10:0];
      a = '0; a[10:0] = 11'(sz); a[12] = cl; a[13] = op; a[20:16] = 5'(off);
      mem[w] = a; w++;
      mem[w] = {tg, 5'd0, ln}; w++;
      if (op) begin ptag = tg; plen = ln; cnt = 0; perr = 1'b0; end
      else if (tg != ptag || ln != plen) perr = 1'b1;
      nb = ((off + sz + 3) / 4) * 4;
      for (int p = 0; p < nb; p++) begin
        logic [7:0] b;
        if (p >= off && p < off + sz) begin
          b = pay(v, p);
          exp_b[ne] = b; exp_f[ne] = (cnt == 0); exp_l[ne] = cl && (p == off + sz - 1);
          ne++; cnt++;
        end else b = 8'hC3;
        if (p % 4 == 0) mem[w] = '0;
        mem[w][8*(p%4) +: 8] = b;
        if (p % 4 == 3) w++;
      end
      if (cl) begin
        exp_s[ns] = {ptag, perr || (cnt != int'(plen)), 3'b000, 12'(cnt)};
        ns++;
      end
      wend[v] = w;
      if (v == NV - 2) begin ne1 = ne; ns1 = ns; end
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!out_valid, "R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk(!sts_write, "R1 sts_write in reset", {31'd0, sts_write}, 32'd0);
    chk(fifo_ready, "R1 fifo_ready in reset", {31'd0, fifo_ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && fifo_ready, "R1 first cycle after reset",
        {30'd0, out_valid, fifo_ready}, 32'd1);

    limit = wend[NV-2];
    wait_for(ne1, ns1);
    // R8 R9 R10 R11 R12: one status per packet with expected fields
    chk(nsg == ns1, "R8 status count", 32'(nsg), 32'(ns1));
    for (int i = 0; i < ns1; i++)
      chk(cap_s[i] === exp_s[i], $sformatf("R8 R9 R10 R11 R12 status %0d", i), cap_s[i], exp_s[i]);
    // R5 R12: every word consumed, stream aligned
    chk(int'(rd) == limit, "R5 R12 words consumed", 32'(rd), 32'(limit));

    // R13: status held back while the status FIFO is full
    @(negedge clk);
    hold_full = 1'b1; ready_all = 1'b1;
    @(negedge clk);
    limit = wend[NV-1];
    repeat (60) @(negedge clk);
    chk(nsg == ns1, "R13 no write while full", 32'(nsg), 32'(ns1));
    chk(nc == ne, "R13 bytes sent before status", 32'(nc), 32'(ne));
    hold_full = 1'b0;
    wait_for(ne, ns);
    repeat (3) @(negedge clk);
    chk(nsg == ns, "R8 R13 single write after release", 32'(nsg), 32'(ns));
    chk(cap_s[ns-1] === exp_s[ns-1], "R13 held status value", cap_s[ns-1], exp_s[ns-1]);

    // R2 R3 R4 R5 R6: byte stream with markers
    chk(nc == ne, "R4 R5 byte count", 32'(nc), 32'(ne));
    for (int i = 0; i < ne; i++)
      chk({cap_b[i], cap_f[i], cap_l[i]} === {exp_b[i], exp_f[i], exp_l[i]},
          $sformatf("R2 R3 R4 R5 R6 byte %0d", i),
          {22'd0, cap_b[i], cap_f[i], cap_l[i]}, {22'd0, exp_b[i], exp_f[i], exp_l[i]});

    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    chk(1'b0, "watchdog global", 32'(cyc), 32'd100000);
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end
endmodule